// File: doc/BRIEF.md
# Banded Multi-CPU Interrupt Controller

This block gathers 64 interrupt vectors into one sticky pending word. A vector becomes pending when its hardware source line is high on a clock edge, or when software writes a 1 for it into the set register. It leaves the pending state only when software writes a 1 for it into the clear register. The pending word itself can be read but not written.

Each CPU, up to four of them, owns a 64-bit enable mask. The vector space is cut into five fixed priority bands by bit range. For every CPU and every band, the block drives one registered output line. The line is high while any vector of that band is both pending and enabled in that CPU's mask.

Software reaches the block through a flat 64-bit register bus. The bus has a byte address, a single-cycle write strobe with write data, and combinational read data. Software raises inter-processor requests, such as reschedule and cross-call, by writing the matching pending bit through the set register.

Top module: `irq_band_ctrl`

## Requirements
- R1: After reset, all mask registers and the pending word read zero and every output line is low. An empty pending word drives every output low one clock later.
- R2: A write to byte address 0x20 (set) ORs every 1 bit of the write data into the pending word at that clock edge.
- R3: A write to byte address 0x28 (clear) clears each pending bit written as 1. Pending bits written as 0 keep their value.
- R4: A source input high at a clock edge sets its pending bit. The bit stays set after the input falls, until it is cleared.
- R5: When a source input and a clear write hit the same bit at the same edge, the bit ends up set.
- R6: A write to byte address 0x30 (pending status, read-only) leaves the pending word unchanged.
- R7: The mask of CPU c sits at byte address 8*c (0x00, 0x08, 0x10, 0x18). A write stores the data there, and a read returns it.
- R8: The bands are fixed: band 4 = bits 63..51, band 3 = bit 50, band 2 = bits 49..32, band 1 = bits 31..16, band 0 = bits 15..0. Output irq_o[5*c+k] serves CPU c, band k.
- R9: Output irq_o[5*c+k] is the OR over band k of (pending AND mask c), registered one clock after the pending word or the mask changes. It therefore rises and falls one cycle after the write edge.
- R10: A read of byte address 0x40 (cause) returns the pending word ANDed with the OR of all CPU masks.
- R11: Reads of any other address, including the write-only set and clear addresses and unaligned addresses, return zero. Writes to unaligned or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 64 | Write data |
| rd_data_o | output | 64 | Read data for addr_i, combinational |
| src_i | input | 64 | Hardware interrupt sources, one per vector |
| irq_o | output | 20 | Per-CPU per-band interrupt lines, index 5*cpu+band |

## Verification
The bench sets a single bit at each band edge: 0, 15, 16, 31, 32, 49, 50, 51 and 63. A design with a band boundary shifted by one lights the wrong line, or no line, for one of those bits. A bench-side model checks the full 20-bit output vector under four differently shaped masks, which catches a band or CPU index swapped in the output packing. A source and a clear hitting the same bit on the same edge catches a design that lets the clear win and drops the interrupt. The bench also checks the first sample after a write and expects the old output value there, which catches an output that is combinational or delayed by two cycles. Writes to the status address and to an unaligned address must leave the pending word unchanged, which catches a decoder that treats either as a real write.

// File: rtl/irq_band_pkg.sv
package irq_band_pkg;

    localparam int unsigned VEC_W   = 64;
    localparam int unsigned NUM_LVL = 5;

    // Band bounds, inclusive, indexed by priority level
    localparam int unsigned BAND_LO [NUM_LVL] = '{0, 16, 32, 50, 51};
    localparam int unsigned BAND_HI [NUM_LVL] = '{15, 31, 49, 50, 63};

    // Byte offsets of the register map
    localparam int unsigned OFS_MASK0   = 'h00;
    localparam int unsigned MASK_STRIDE = 8;
    localparam int unsigned OFS_SET     = 'h20;
    localparam int unsigned OFS_CLR     = 'h28;
    localparam int unsigned OFS_STAT    = 'h30;
    localparam int unsigned OFS_CAUSE   = 'h40;
    localparam int unsigned WORD_SHIFT  = 3;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_STAT,
        SEL_CAUSE
    } rd_sel_e;

    typedef struct packed {
        vec_t pend;
    } pend_st_t;

    function automatic vec_t band_mask(input int unsigned lvl);
        vec_t m;
        m = '0;
        for (int unsigned b = 0; b < VEC_W; b++) begin
            if (b >= BAND_LO[lvl] && b <= BAND_HI[lvl]) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
    import irq_band_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned ADDR_W  = 8,
    localparam int unsigned CPU_IW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    output logic [NUM_CPU-1:0] mask_we_o,
    output logic               set_we_o,
    output logic               clr_we_o,
    output rd_sel_e            rd_sel_o,
    output logic [CPU_IW-1:0]  rd_cpu_o
);
    localparam int unsigned WORD_W    = ADDR_W - WORD_SHIFT;
    localparam int unsigned W_MASK0   = OFS_MASK0 >> WORD_SHIFT;
    localparam int unsigned W_STRIDE  = MASK_STRIDE >> WORD_SHIFT;
    localparam int unsigned W_SET     = OFS_SET >> WORD_SHIFT;
    localparam int unsigned W_CLR     = OFS_CLR >> WORD_SHIFT;
    localparam int unsigned W_STAT    = OFS_STAT >> WORD_SHIFT;
    localparam int unsigned W_CAUSE   = OFS_CAUSE >> WORD_SHIFT;

    logic              aligned;
    logic [WORD_W-1:0] word;

    assign aligned = (addr_i[WORD_SHIFT-1:0] == '0);
    assign word    = addr_i[ADDR_W-1:WORD_SHIFT];

    always_comb begin
        mask_we_o = '0;
        rd_sel_o  = SEL_NONE;
        rd_cpu_o  = '0;
        for (int unsigned c = 0; c < NUM_CPU; c++) begin
            if (aligned && word == WORD_W'(W_MASK0 + c * W_STRIDE)) begin
                mask_we_o[c] = wr_en_i;
                rd_sel_o     = SEL_MASK;
                rd_cpu_o     = CPU_IW'(c);
            end
        end
        if (aligned && word == WORD_W'(W_STAT))  rd_sel_o = SEL_STAT;
        if (aligned && word == WORD_W'(W_CAUSE)) rd_sel_o = SEL_CAUSE;
    end

    assign set_we_o = wr_en_i && aligned && (word == WORD_W'(W_SET));
    assign clr_we_o = wr_en_i && aligned && (word == WORD_W'(W_CLR));

endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_band_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  vec_t src_i,
    input  logic set_we_i,
    input  logic clr_we_i,
    input  vec_t wdata_i,
    output vec_t pend_o
);
    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we_i) st_d.pend = st_d.pend & ~wdata_i;
        if (set_we_i) st_d.pend = st_d.pend | wdata_i;
        // sources applied last so a same-edge clear loses
        st_d.pend = st_d.pend | src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R2: every written set bit is pending afterwards
    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_i |=> ((pend_o & $past(wdata_i)) == $past(wdata_i)));

    // R3: cleared bits are gone unless a source refills them
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && ((src_i & wdata_i) == '0)) |=> ((pend_o & $past(wdata_i)) == '0));

    // R4: without a clear no pending bit is lost
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

    // R5: a live source always ends pending, even against a clear
    a_r5_source_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((pend_o & $past(src_i)) == $past(src_i)));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_band_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CPU-1:0]       mask_we_i,
    input  vec_t                     wdata_i,
    output logic [NUM_CPU*VEC_W-1:0] mask_o
);
    typedef struct packed {
        logic [NUM_CPU-1:0][VEC_W-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int unsigned c = 0; c < NUM_CPU; c++) begin
            if (mask_we_i[c]) st_d.mask[c] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    // R7: at most one mask written per cycle
    a_r7_one_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_we_i));

endmodule

// File: rtl/irq_band_out.sv
module irq_band_out
    import irq_band_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    localparam int unsigned OUT_W  = NUM_CPU * NUM_LVL
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  vec_t                     pend_i,
    input  logic [NUM_CPU*VEC_W-1:0] mask_i,
    output logic [OUT_W-1:0]         irq_o
);
    typedef struct packed {
        logic [OUT_W-1:0] irq;
    } out_st_t;

    out_st_t          st_d, st_q;
    logic [OUT_W-1:0] hit;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        vec_t live;
        assign live = pend_i & mask_i[c*VEC_W +: VEC_W];
        for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
            assign hit[c*NUM_LVL+k] = |(live & band_mask(k));
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/irq_band_ctrl.sv
module irq_band_ctrl
    import irq_band_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned ADDR_W  = 8,
    localparam int unsigned OUT_W  = NUM_CPU * NUM_LVL,
    localparam int unsigned CPU_IW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [VEC_W-1:0]  wdata_i,
    output logic [VEC_W-1:0]  rd_data_o,
    input  logic [VEC_W-1:0]  src_i,
    output logic [OUT_W-1:0]  irq_o
);
    logic [NUM_CPU-1:0]       mask_we;
    logic                     set_we;
    logic                     clr_we;
    rd_sel_e                  rd_sel;
    logic [CPU_IW-1:0]        rd_cpu;
    vec_t                     pend;
    logic [NUM_CPU*VEC_W-1:0] mask_flat;
    vec_t                     mask_arr [NUM_CPU];
    vec_t                     any_mask;

    irq_addr_dec #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
        .addr_i    (addr_i),
        .wr_en_i   (wr_en_i),
        .mask_we_o (mask_we),
        .set_we_o  (set_we),
        .clr_we_o  (clr_we),
        .rd_sel_o  (rd_sel),
        .rd_cpu_o  (rd_cpu)
    );

    irq_pend_reg u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .set_we_i (set_we),
        .clr_we_i (clr_we),
        .wdata_i  (wdata_i),
        .pend_o   (pend)
    );

    irq_mask_bank #(.NUM_CPU(NUM_CPU)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we_i (mask_we),
        .wdata_i   (wdata_i),
        .mask_o    (mask_flat)
    );

    irq_band_out #(.NUM_CPU(NUM_CPU)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .mask_i (mask_flat),
        .irq_o  (irq_o)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_arr
        assign mask_arr[c] = mask_flat[c*VEC_W +: VEC_W];
    end

    always_comb begin
        any_mask = '0;
        for (int unsigned c = 0; c < NUM_CPU; c++) any_mask = any_mask | mask_arr[c];
    end

    always_comb begin
        unique case (rd_sel)
            SEL_MASK:  rd_data_o = mask_arr[rd_cpu];
            SEL_STAT:  rd_data_o = pend;
            SEL_CAUSE: rd_data_o = pend & any_mask;
            default:   rd_data_o = '0;
        endcase
    end

    // R1: nothing pending means every line low on the next cycle
    a_r1_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (irq_o == '0));

    // R6: writing the status address with no source active changes nothing
    a_r6_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFS_STAT) && src_i == '0) |=> $stable(pend));

    // R11: a write decodes to at most one target
    a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mask_we, set_we, clr_we}) <= 1);

endmodule

// File: tb/irq_band_ctrl_bench.sv
module irq_band_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rd_data;
    logic [63:0] src = '0;
    logic [19:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] mm [4];

    always #10 clk = ~clk;

    irq_band_ctrl u_irq_band_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wdata_i   (wdata),
        .rd_data_o (rd_data),
        .src_i     (src),
        .irq_o     (irq)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [63:0] d;
        logic [63:0] pend;
    } step_t;

    localparam int NSTEP = 13;
    localparam step_t STEPS [NSTEP] = '{
        '{8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        '{8'h08, 64'h0004_0000_0000_FFFF, 64'h0},
        '{8'h10, 64'h0000_C000_0000_0000, 64'h0},
        '{8'h18, 64'hFFF8_0000_FFFF_0000, 64'h0},
        '{8'h20, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001},
        '{8'h20, 64'h0000_4000_0000_0000, 64'h0000_4000_0000_0001},
        '{8'h20, 64'h0004_0000_0000_0000, 64'h0004_4000_0000_0001},
        '{8'h20, 64'h8000_0000_0001_0000, 64'h8004_4000_0001_0001},
        '{8'h28, 64'h0000_4000_0000_0001, 64'h8004_0000_0001_0000},
        '{8'h30, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8004_0000_0001_0000},
        '{8'h28, 64'h8000_0000_0001_0000, 64'h0004_0000_0000_0000},
        '{8'h20, 64'h0008_0000_0000_8000, 64'h000C_0000_0000_8000},
        '{8'h28, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0}
    };

    function automatic int lvl_of(input int b);
        if (b >= 51) return 4;
        if (b == 50) return 3;
        if (b >= 32) return 2;
        if (b >= 16) return 1;
        return 0;
    endfunction

    function automatic logic [19:0] model_irq(input logic [63:0] p);
        logic [19:0] r;
        r = '0;
        for (int c = 0; c < 4; c++)
            for (int b = 0; b < 64; b++)
                if (p[b] && mm[c][b]) r[c*5 + lvl_of(b)] = 1'b1;
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 8'h20 && a[2:0] == 3'b0) mm[a[4:3]] = d;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        for (int c = 0; c < 4; c++) mm[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R1: reset state
        check("R1 irq after reset", 64'(irq), 64'h0);
        rd(8'h30, v); check("R1 pending after reset", v, 64'h0);
        for (int c = 0; c < 4; c++) begin
            rd(8'(c * 8), v); check("R1 mask after reset", v, 64'h0);
        end

        // Table walk: R2 R3 R6 R7 R8 R9
        for (int i = 0; i < NSTEP; i++) begin
            do_write(STEPS[i].a, STEPS[i].d);
            idle();
            rd(8'h30, v); check("R2/R3/R6 pending", v, STEPS[i].pend);
            check("R8/R9 irq", 64'(irq), 64'(model_irq(STEPS[i].pend)));
        end

        // R7: mask readback
        rd(8'h08, v); check("R7 mask1", v, 64'h0004_0000_0000_FFFF);
        rd(8'h18, v); check("R7 mask3", v, 64'hFFF8_0000_FFFF_0000);

        // R8: band edges seen on CPU 0 (all-ones mask)
        begin
            int bits [9] = '{0, 15, 16, 31, 32, 49, 50, 51, 63};
            int lvls [9] = '{0, 0, 1, 1, 2, 2, 3, 4, 4};
            for (int i = 0; i < 9; i++) begin
                do_write(8'h20, 64'h1 << bits[i]);
                idle();
                check("R8 band edge cpu0", 64'(irq[4:0]), 64'h1 << lvls[i]);
                check("R8 band edge all", 64'(irq), 64'(model_irq(64'h1 << bits[i])));
                do_write(8'h28, 64'h1 << bits[i]);
                idle();
            end
        end

        // R9: one-cycle latency on rise and fall
        do_write(8'h20, 64'h0000_0000_0002_0000);
        check("R9 rise not yet", 64'(irq), 64'h0);
        idle();
        check("R9 rise", 64'(irq), 64'(model_irq(64'h0000_0000_0002_0000)));
        do_write(8'h28, 64'h0000_0000_0002_0000);
        check("R9 fall not yet", 64'(irq), 64'(model_irq(64'h0000_0000_0002_0000)));
        idle();
        check("R9 fall", 64'(irq), 64'h0);

        // R4: one-cycle source pulse is held
        @(negedge clk); src = 64'h1 << 59;
        @(negedge clk); src = '0;
        repeat (3) idle();
        rd(8'h30, v); check("R4 sticky source", v, 64'h1 << 59);
        check("R4 irq from source", 64'(irq), 64'(model_irq(64'h1 << 59)));

        // R5: source beats a clear on the same edge
        @(negedge clk);
        src = 64'h1 << 60; addr = 8'h28; wdata = (64'h1 << 60) | (64'h1 << 59); wr_en = 1'b1;
        @(negedge clk);
        src = '0; wr_en = 1'b0;
        rd(8'h30, v); check("R5 set wins", v, 64'h1 << 60);

        // R11: unaligned write ignored, unmapped reads zero
        do_write(8'h21, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h30, v); check("R11 unaligned write", v, 64'h1 << 60);
        rd(8'h20, v); check("R11 set reads zero", v, 64'h0);
        rd(8'h38, v); check("R11 0x38 reads zero", v, 64'h0);
        rd(8'h48, v); check("R11 0x48 reads zero", v, 64'h0);
        rd(8'h01, v); check("R11 unaligned read", v, 64'h0);

        // R10: cause uses the union of masks
        do_write(8'h00, 64'h0);
        do_write(8'h20, (64'h1 << 20) | (64'h1 << 5) | (64'h1 << 40));
        rd(8'h40, v);
        check("R10 cause", v, ((64'h1 << 60) | (64'h1 << 20) | (64'h1 << 5) | (64'h1 << 40))
                              & (mm[0] | mm[1] | mm[2] | mm[3]));

        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1 irq in reset", 64'(irq), 64'h0);
        rd(8'h30, v); check("R1 pending in reset", v, 64'h0);
        rd(8'h18, v); check("R1 mask in reset", v, 64'h0);

        finish_run();
    end

endmodule